// File: doc/BRIEF.md
# RTC Clock Source Selector

This block picks the kernel tick for a real-time clock from one of three sources. The first is a high-speed oscillator brought down by a factor of 32. The second is a low-speed crystal oscillator, and the third is a low-speed on-chip RC oscillator. All clocks are modelled as single-cycle enable pulses on one fast fabric clock. The output `rtc_tick` is one such enable pulse.

The choice of source sits in a register kept in the backup domain. The first write of a non-zero code locks the register, and only a backup-domain reset unlocks it again. A system reset leaves the choice and the lock alone. While a system reset is held, the low-speed sources keep ticking, and the divided high-speed path stays quiet. The crystal source is the only one that still ticks when the core power domain or the main supply is reported off.

A monitor watches the relation between the bus clock enable and the RTC tick. It raises a sticky flag when the bus clock is too slow to see every tick. Software reads this flag to detect a clock setup that breaks the required ordering. The block has no streaming data path: all pins are plain control and status.

Top module: `rtc_clk_sel`

## Requirements
- R1: After a backup-domain reset and a system reset are both released, `src_sel` is 00, `src_locked` is 0, `rtc_tick` is 0 and `bus_slow` is 0.
- R2: The code in `src_sel` chooses the tick source as follows. 01 passes `lo_xtal_en` and 10 passes `lo_rc_en`, both in the same cycle. 11 passes the divided high-speed output. 00 gives no tick.
- R3: A write (`src_wr` high at a clock edge) while unlocked loads `src_wdata`. The lock sets only if the written code is non-zero. While the lock is set, writes leave `src_sel` unchanged.
- R4: A system reset clears neither `src_sel` nor `src_locked`. A backup-domain reset clears both.
- R5: The high-speed divider is a 5-bit counter that advances on each `hi_osc_en`. When code 11 is selected, `rtc_tick` is high in the cycle of every 32nd `hi_osc_en`, counted from the last system reset.
- R6: While `sys_rst_n` is low, codes 01 and 10 still pass their source enable. Code 11 gives no tick, and its divider is held at zero.
- R7: When `core_pwr_off` or `main_pwr_off` is high, `rtc_tick` is 0 for codes 10 and 11. Code 01 is unaffected.
- R8: `bus_slow` sets in the cycle after an `rtc_tick` if three things hold: an earlier tick has occurred, no `bus_clk_en` has come since it, and `bus_clk_en` is low in the cycle of the new tick. A `bus_clk_en` in the same cycle as a tick counts as arriving before that tick. The flag stays set until a system reset.
- R9: Writes made while `sys_rst_n` is low are ignored.
- R10: `rtc_tick` is 0 while `bkp_rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock; all enables are sampled on its rising edge |
| bkp_rst_n | input | 1 | Backup-domain reset, active low, synchronous |
| sys_rst_n | input | 1 | System reset, active low, synchronous |
| hi_osc_en | input | 1 | Enable pulse of the high-speed oscillator |
| lo_xtal_en | input | 1 | Enable pulse of the low-speed crystal oscillator |
| lo_rc_en | input | 1 | Enable pulse of the low-speed RC oscillator |
| bus_clk_en | input | 1 | Enable pulse of the peripheral bus clock |
| src_wr | input | 1 | Write strobe for the source code |
| src_wdata | input | 2 | Source code to write |
| core_pwr_off | input | 1 | Core power domain is off |
| main_pwr_off | input | 1 | Main supply is off |
| rtc_tick | output | 1 | Selected RTC kernel enable |
| src_sel | output | 2 | Current source code |
| src_locked | output | 1 | Source code is locked |
| bus_slow | output | 1 | Sticky flag: bus clock too slow for the RTC tick |

## Verification
A tick and a bus clock enable can arrive in the same cycle. The same-cycle rule in R8 decides whether that case is an error. The bench drives both enables at full rate for a stretch, and the flag must stay low. It then drops the bus enable to a low rate while the crystal ticks often, and the flag must rise exactly one cycle after the second unseparated tick. A cycle-by-cycle model in the bench applies the same ordering and compares `bus_slow` and `rtc_tick` on every clock.

// File: rtl/rtc_clk_pkg.sv
package rtc_clk_pkg;
  typedef enum logic [1:0] {
    SRC_OFF     = 2'b00,
    SRC_LO_XTAL = 2'b01,
    SRC_LO_RC   = 2'b10,
    SRC_HI_DIV  = 2'b11
  } rtc_src_e;
endpackage

// File: rtl/rtc_src_reg.sv
module rtc_src_reg
  import rtc_clk_pkg::*;
(
  input  logic     clk,
  input  logic     bkp_rst_n,
  input  logic     sys_rst_n,
  input  logic     wr,
  input  rtc_src_e wdata,
  output rtc_src_e src,
  output logic     locked
);
  // Backup-domain register: only bkp_rst_n clears it.
  always_ff @(posedge clk) begin
    if (!bkp_rst_n) begin
      src    <= SRC_OFF;
      locked <= 1'b0;
    end else if (wr && sys_rst_n && !locked) begin
      src    <= wdata;
      locked <= (wdata != SRC_OFF);
    end
  end

  // R3: a locked code never changes until backup reset
  a_r3_locked_hold: assert property (@(posedge clk) disable iff (!bkp_rst_n)
    locked |=> (src == $past(src)));
  // R3: lock implies a non-zero code was taken
  a_r3_lock_nonzero: assert property (@(posedge clk) disable iff (!bkp_rst_n)
    locked |-> (src != SRC_OFF));
  // R9: a write under system reset leaves the code alone
  a_r9_sysrst_write: assert property (@(posedge clk) disable iff (!bkp_rst_n)
    !sys_rst_n |=> (src == $past(src)));
endmodule

// File: rtl/rtc_hi_div.sv
module rtc_hi_div #(
  parameter int DIV_W = 5
) (
  input  logic clk,
  input  logic sys_rst_n,
  input  logic en,
  output logic pulse
);
  logic [DIV_W-1:0] cnt;

  // Lies outside the backup domain, so system reset clears it.
  always_ff @(posedge clk) begin
    if (!sys_rst_n)  cnt <= '0;
    else if (en)     cnt <= cnt + 1'b1;
  end

  assign pulse = sys_rst_n && en && (cnt == {DIV_W{1'b1}});

  // R5: the count only moves on a high-speed enable
  a_r5_count_hold: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !en |=> $stable(cnt));
  // R5: a pulse is always followed by a wrapped counter
  a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!sys_rst_n)
    pulse |=> (cnt == '0));
endmodule

// File: rtl/rtc_bus_mon.sv
module rtc_bus_mon (
  input  logic clk,
  input  logic sys_rst_n,
  input  logic tick,
  input  logic bus_en,
  output logic slow
);
  logic pend;

  // A bus enable in the tick's own cycle counts as seen before the tick.
  always_ff @(posedge clk) begin
    if (!sys_rst_n) begin
      pend <= 1'b0;
      slow <= 1'b0;
    end else begin
      if (tick && pend && !bus_en) slow <= 1'b1;
      if (tick)        pend <= 1'b1;
      else if (bus_en) pend <= 1'b0;
    end
  end

  // R8: flag is sticky until system reset
  a_r8_sticky: assert property (@(posedge clk) disable iff (!sys_rst_n)
    slow |=> slow);
  // R8: a tick with a coincident bus enable never raises the flag
  a_r8_same_cycle: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (!slow && tick && bus_en) |=> !slow);
endmodule

// File: rtl/rtc_clk_sel.sv
module rtc_clk_sel
  import rtc_clk_pkg::*;
#(
  parameter int DIV_W = 5
) (
  input  logic       clk,
  input  logic       bkp_rst_n,
  input  logic       sys_rst_n,
  input  logic       hi_osc_en,
  input  logic       lo_xtal_en,
  input  logic       lo_rc_en,
  input  logic       bus_clk_en,
  input  logic       src_wr,
  input  logic [1:0] src_wdata,
  input  logic       core_pwr_off,
  input  logic       main_pwr_off,
  output logic       rtc_tick,
  output logic [1:0] src_sel,
  output logic       src_locked,
  output logic       bus_slow
);
  rtc_src_e src;
  logic     hi_pulse;
  logic     pwr_lost;

  rtc_src_reg u_src (
    .clk       (clk),
    .bkp_rst_n (bkp_rst_n),
    .sys_rst_n (sys_rst_n),
    .wr        (src_wr),
    .wdata     (rtc_src_e'(src_wdata)),
    .src       (src),
    .locked    (src_locked)
  );

  rtc_hi_div #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .sys_rst_n (sys_rst_n),
    .en        (hi_osc_en),
    .pulse     (hi_pulse)
  );

  assign pwr_lost = core_pwr_off || main_pwr_off;

  always_comb begin
    rtc_tick = 1'b0;
    if (bkp_rst_n) begin
      unique case (src)
        SRC_LO_XTAL: rtc_tick = lo_xtal_en;
        SRC_LO_RC:   rtc_tick = lo_rc_en && !pwr_lost;
        SRC_HI_DIV:  rtc_tick = hi_pulse && !pwr_lost;
        default:     rtc_tick = 1'b0;
      endcase
    end
  end

  assign src_sel = src;

  rtc_bus_mon u_mon (
    .clk       (clk),
    .sys_rst_n (sys_rst_n),
    .tick      (rtc_tick),
    .bus_en    (bus_clk_en),
    .slow      (bus_slow)
  );

  // R7: lost power silences every source but the crystal
  a_r7_pwr_gate: assert property (@(posedge clk) disable iff (!bkp_rst_n)
    (pwr_lost && src != SRC_LO_XTAL) |-> !rtc_tick);
  // R6: divided high-speed path is quiet in system reset
  a_r6_hi_sysrst: assert property (@(posedge clk) disable iff (!bkp_rst_n)
    (!sys_rst_n && src == SRC_HI_DIV) |-> !rtc_tick);
  // R6: crystal keeps ticking through system reset
  a_r6_xtal_sysrst: assert property (@(posedge clk) disable iff (!bkp_rst_n)
    (!sys_rst_n && src == SRC_LO_XTAL && lo_xtal_en) |-> rtc_tick);
  // R10: no tick while backup reset is held
  a_r10_bkp_quiet: assert property (@(posedge clk)
    !bkp_rst_n |-> !rtc_tick);
endmodule

// File: tb/rtc_clk_sel_test.sv
module rtc_clk_sel_test;
  logic clk = 1'b0;
  logic bkp_rst_n = 1'b0, sys_rst_n = 1'b0;
  logic hi_osc_en = 1'b0, lo_xtal_en = 1'b0, lo_rc_en = 1'b0, bus_clk_en = 1'b0;
  logic src_wr = 1'b0;
  logic [1:0] src_wdata = 2'b00;
  logic core_pwr_off = 1'b0, main_pwr_off = 1'b0;
  logic rtc_tick, src_locked, bus_slow;
  logic [1:0] src_sel;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string tag = "R1";
  int p_hi = 0, p_xt = 0, p_rc = 0, p_bus = 0;

  // behavioural reference state
  int m_sel = 0, m_lock = 0, m_hcnt = 0, m_pend = 0, m_err = 0;

  always #2 clk = ~clk;

  rtc_clk_sel uut (
    .clk(clk), .bkp_rst_n(bkp_rst_n), .sys_rst_n(sys_rst_n),
    .hi_osc_en(hi_osc_en), .lo_xtal_en(lo_xtal_en), .lo_rc_en(lo_rc_en),
    .bus_clk_en(bus_clk_en), .src_wr(src_wr), .src_wdata(src_wdata),
    .core_pwr_off(core_pwr_off), .main_pwr_off(main_pwr_off),
    .rtc_tick(rtc_tick), .src_sel(src_sel), .src_locked(src_locked),
    .bus_slow(bus_slow)
  );

  function automatic int exp_tick();
    if (!bkp_rst_n) return 0;
    if (m_sel == 1) return int'(lo_xtal_en);
    if (core_pwr_off || main_pwr_off) return 0;
    if (m_sel == 2) return int'(lo_rc_en);
    if (m_sel == 3) return (sys_rst_n && hi_osc_en && m_hcnt == 31) ? 1 : 0;
    return 0;
  endfunction

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, compare, then advance the model at posedge
  task automatic step(bit wr = 0, int wd = 0);
    int t;
    hi_osc_en  = ($urandom % 100) < p_hi;
    lo_xtal_en = ($urandom % 100) < p_xt;
    lo_rc_en   = ($urandom % 100) < p_rc;
    bus_clk_en = ($urandom % 100) < p_bus;
    src_wr = wr;
    src_wdata = wd[1:0];
    #1;
    t = exp_tick();
    chk("rtc_tick", int'(rtc_tick), t);
    chk("src_sel", int'(src_sel), m_sel);
    chk("src_locked", int'(src_locked), m_lock);
    chk("bus_slow", int'(bus_slow), m_err);
    @(posedge clk);
    if (!bkp_rst_n) begin m_sel = 0; m_lock = 0; end
    else if (wr && sys_rst_n && !m_lock) begin m_sel = wd; m_lock = (wd != 0); end
    if (!sys_rst_n) m_hcnt = 0; else if (hi_osc_en) m_hcnt = (m_hcnt + 1) % 32;
    if (!sys_rst_n) begin m_pend = 0; m_err = 0; end
    else begin
      if (t != 0 && m_pend != 0 && !bus_clk_en) m_err = 1;
      if (t != 0) m_pend = 1; else if (bus_clk_en) m_pend = 0;
    end
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    @(negedge clk);
    // R10: backup reset held, sources active, a write attempt
    tag = "R10"; p_xt = 50; p_rc = 50; p_hi = 50;
    step(1, 1); run(3);
    bkp_rst_n = 1'b1; sys_rst_n = 1'b1;
    tag = "R1"; p_xt = 0; p_rc = 0; p_hi = 0;
    run(4);
    // R3: zero write does not lock, then crystal locks
    tag = "R3"; step(1, 0); run(2); step(1, 1); run(2);
    tag = "R2"; p_xt = 40; p_bus = 100; run(50);
    tag = "R3"; step(1, 3); step(1, 2); run(10);
    // R6 and R4: system reset keeps crystal ticks and the lock
    tag = "R6/R4"; sys_rst_n = 1'b0; run(20); sys_rst_n = 1'b1; run(3);
    tag = "R7"; main_pwr_off = 1'b1; core_pwr_off = 1'b1; run(20);
    main_pwr_off = 1'b0; core_pwr_off = 1'b0;
    // R8: both enables at full rate, flag must stay low
    tag = "R8"; p_xt = 100; p_bus = 100; run(30);
    p_xt = 60; p_bus = 5; run(40);
    sys_rst_n = 1'b0; run(1); sys_rst_n = 1'b1; p_bus = 30; p_xt = 30; run(60);
    sys_rst_n = 1'b0; run(1); sys_rst_n = 1'b1; p_xt = 0; p_bus = 100;
    // R4: backup reset clears the lock
    tag = "R4"; bkp_rst_n = 1'b0; run(2); bkp_rst_n = 1'b1; run(2);
    tag = "R9"; sys_rst_n = 1'b0; step(1, 2); run(2); sys_rst_n = 1'b1; run(2);
    tag = "R2"; step(1, 2); p_rc = 50; run(40);
    tag = "R7"; core_pwr_off = 1'b1; run(15); core_pwr_off = 1'b0;
    main_pwr_off = 1'b1; run(15); main_pwr_off = 1'b0;
    // R5: divided high-speed source
    tag = "R4"; bkp_rst_n = 1'b0; run(2); bkp_rst_n = 1'b1;
    tag = "R5"; p_rc = 0; p_hi = 80; step(1, 3); run(300);
    p_hi = 100; run(100);
    tag = "R6"; sys_rst_n = 1'b0; run(40); sys_rst_n = 1'b1;
    tag = "R5"; run(150);
    tag = "R7"; core_pwr_off = 1'b1; run(80); core_pwr_off = 1'b0;
    tag = "R5"; run(70);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule